// File: doc/BRIEF.md
# Serial Link Error Response Controller

This block sits behind the frame decoder of a serial memory-channel link. It reacts to link faults. For each decoded southbound frame it receives the result of the CRC check on the command part and on the data part, plus a flag that marks a sync frame. It also receives soft channel reset and link reset indications and a three-bit fault enable mask. It decides whether the frame's command may run. On a fault it records the offending frame and the fault type. It then holds the channel in a lockout state until the right kind of reset arrives.

There are two fault classes. A CRC fault on an enabled type blocks the frame's command. It then refuses every later command until a soft channel reset or a link reset. A CRC fault never touches DRAM state. Loss of sync is declared when too many frames go by without a sync frame. An enabled sync loss blocks the command and asks the DRAM side to enter self refresh. It then refuses every command, soft reset included, until a link reset. In both cases the northbound side is told to send alert frames, starting a fixed number of cycles after the fault, up to the reset that ends the lockout. The CRC checkers, the serialiser and the DRAM controller are separate blocks. Write-buffer overrun and underrun have no path into this block.

The controller is a three-state machine: `ST_RUN` (normal), `ST_CRC_LOCK` (CRC lockout) and `ST_SYNC_LOCK` (sync-loss lockout). It has these transitions:
- RUN to CRC_LOCK on an enabled CRC fault.
- RUN or CRC_LOCK to SYNC_LOCK on an enabled sync loss.
- CRC_LOCK to RUN on a soft reset frame.
- Any state to RUN on link reset.

Top module: `link_fault_ctrl`

## Requirements
- R1: In ST_RUN, a frame with `frame_valid`=1 and no enabled fault drives `cmd_exec`=1 in the same cycle. `cmd_exec` is never 1 without `frame_valid`.
- R2: A fault whose mask bit is 0 is ignored. The command executes, nothing is logged and the state does not change. The mask bits are: bit 0 command CRC, bit 1 data CRC, bit 2 sync loss.
- R3: An enabled CRC fault (command or data) in ST_RUN drives `cmd_exec`=0 for that frame. After the next clock edge, `log_strobe`=1 for one cycle, `log_frame` holds the faulty frame, `alert_status`=1 and the state is ST_CRC_LOCK.
- R4: Error types use the mask bit coding. The first logged fault since the last clear loads `first_err`. Every later logged fault ORs its type bits into `next_err`, and `first_err` stays unchanged.
- R5: In ST_CRC_LOCK, `cmd_exec` stays 0 for every frame. A soft reset frame (`soft_rst`=1 with `frame_valid`=1) returns the state to ST_RUN.
- R6: Sync loss is declared on a non-sync frame when it is the 2×`sync_interval`-th consecutive non-sync frame since the last sync frame, soft reset or link reset. Frames are not counted while `link_active`=0. `sync_interval`=0 disables the check.
- R7: An enabled sync loss drives `cmd_exec`=0 for that frame, logs it as in R3 with type bit 2, and pulses `self_refresh_req` for exactly one cycle. The state becomes ST_SYNC_LOCK, and only a link reset leaves it. Soft reset frames there are ignored.
- R8: `self_refresh_req` is raised only on entry to ST_SYNC_LOCK. CRC faults never raise it.
- R9: `alert_sel` rises ALERT_DLY cycles after `log_strobe` of the fault that started the lockout. It stays high until the lockout ends.
- R10: `link_rst` returns the state to ST_RUN. It clears `first_err`, `next_err`, `alert_status` and `alert_sel`, and restarts the sync count.
- R11: In ST_CRC_LOCK a further CRC fault is not logged. An enabled sync loss there escalates to ST_SYNC_LOCK, logs type bit 2 into `next_err` and raises `self_refresh_req`.
- R12: While `rst_n`=0 all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_active | input | 1 | Link is in the operational state; sync counting runs only then |
| frame_valid | input | 1 | A decoded southbound frame is present this cycle |
| frame_is_sync | input | 1 | The present frame is a sync frame |
| crc_cmd_err | input | 1 | CRC check of the frame's command failed |
| crc_data_err | input | 1 | CRC check of the frame's data or secondary commands failed |
| soft_rst | input | 1 | The present frame carries a soft channel reset |
| link_rst | input | 1 | Link reset received |
| err_mask | input | 3 | Fault enables: bit 0 command CRC, bit 1 data CRC, bit 2 sync loss |
| sync_interval | input | IVL_W | Sync training interval; the window is twice this many frames |
| raw_frame | input | FRAME_W | Raw southbound frame bits |
| cmd_exec | output | 1 | The present frame's command may execute |
| log_strobe | output | 1 | One-cycle pulse when a fault is captured |
| log_frame | output | FRAME_W | Captured faulty frame |
| first_err | output | 3 | Type of the first logged fault |
| next_err | output | 3 | Accumulated types of later faults |
| alert_status | output | 1 | Sticky alert-asserted status bit |
| self_refresh_req | output | 1 | One-cycle request to put DRAM into self refresh |
| alert_sel | output | 1 | Northbound link sends alert frames while high |

## Verification
The hardest state to reach from the ports is the escalation path: a CRC lockout that then times out on sync and must log into `next_err` and request self refresh. The stimulus raises a command CRC fault on a non-sync frame. It then sends non-sync frames, counting them against twice the sync interval, so the escalating frame is known in advance. The same frame-exact counting sweeps the window for several interval values. It also places a sync frame one frame before expiry to show the reload, and drops `link_active` in mid-window to show the hold.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_CRC_LOCK  = 2'd1,
        ST_SYNC_LOCK = 2'd2
    } lfc_state_e;

    localparam int ERR_W  = 3;
    localparam int E_CMD  = 0;
    localparam int E_DATA = 1;
    localparam int E_SYNC = 2;

endpackage

// File: rtl/sync_loss_timer.sv
module sync_loss_timer #(
    parameter int IVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_active,
    input  logic             frame_valid,
    input  logic             frame_is_sync,
    input  logic             reload,
    input  logic [IVL_W-1:0] interval,
    output logic             sync_lost
);
    localparam int CW = IVL_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] window;
    logic          beat;
    logic          seen_sync;

    assign window    = {interval, 1'b0};
    assign beat      = link_active & frame_valid & ~frame_is_sync;
    assign seen_sync = link_active & frame_valid & frame_is_sync;
    assign sync_lost = beat && !reload && (window != '0) && (cnt == window - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (reload || seen_sync || sync_lost) begin
            cnt <= '0;
        end else if (beat) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/alert_slot_timer.sv
module alert_slot_timer #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic alert_sel
);
    localparam int DW = $clog2(DLY + 2);

    logic          armed;
    logic [DW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (stop) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (start && !armed) begin
            armed <= 1'b1;
            cnt   <= DW'(DLY);
        end else if (armed && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign alert_sel = armed && (cnt == '0);

endmodule

// File: rtl/fault_log.sv
module fault_log
    import lfc_pkg::*;
#(
    parameter int FRAME_W = 120
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               log_go,
    input  logic [ERR_W-1:0]   ev,
    input  logic [FRAME_W-1:0] raw,
    output logic               log_strobe,
    output logic [FRAME_W-1:0] log_frame,
    output logic [ERR_W-1:0]   first_err,
    output logic [ERR_W-1:0]   next_err,
    output logic               alert_status
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            log_strobe   <= 1'b0;
            log_frame    <= '0;
            first_err    <= '0;
            next_err     <= '0;
            alert_status <= 1'b0;
        end else begin
            log_strobe <= 1'b0;
            if (clear) begin
                first_err    <= '0;
                next_err     <= '0;
                alert_status <= 1'b0;
            end else if (log_go) begin
                log_strobe   <= 1'b1;
                log_frame    <= raw;
                alert_status <= 1'b1;
                if (first_err == '0) begin
                    first_err <= ev;
                end else begin
                    next_err <= next_err | ev;
                end
            end
        end
    end

endmodule

// File: rtl/link_fault_ctrl.sv
module link_fault_ctrl
    import lfc_pkg::*;
#(
    parameter int FRAME_W   = 120,
    parameter int IVL_W     = 6,
    parameter int ALERT_DLY = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_active,
    input  logic               frame_valid,
    input  logic               frame_is_sync,
    input  logic               crc_cmd_err,
    input  logic               crc_data_err,
    input  logic               soft_rst,
    input  logic               link_rst,
    input  logic [ERR_W-1:0]   err_mask,
    input  logic [IVL_W-1:0]   sync_interval,
    input  logic [FRAME_W-1:0] raw_frame,
    output logic               cmd_exec,
    output logic               log_strobe,
    output logic [FRAME_W-1:0] log_frame,
    output logic [ERR_W-1:0]   first_err,
    output logic [ERR_W-1:0]   next_err,
    output logic               alert_status,
    output logic               self_refresh_req,
    output logic               alert_sel
);

    lfc_state_e       state, state_d;
    logic             sync_lost;
    logic             sync_ev;
    logic             soft_frame;
    logic [ERR_W-1:0] crc_ev;
    logic [ERR_W-1:0] ev;
    logic             log_go;
    logic             sr_go;
    logic             alert_stop;

    assign soft_frame = soft_rst & frame_valid;
    assign sync_ev    = sync_lost & err_mask[E_SYNC];

    always_comb begin
        crc_ev         = '0;
        crc_ev[E_CMD]  = frame_valid & crc_cmd_err  & err_mask[E_CMD];
        crc_ev[E_DATA] = frame_valid & crc_data_err & err_mask[E_DATA];
    end

    sync_loss_timer #(.IVL_W(IVL_W)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_active  (link_active),
        .frame_valid  (frame_valid),
        .frame_is_sync(frame_is_sync),
        .reload       (link_rst | soft_frame),
        .interval     (sync_interval),
        .sync_lost    (sync_lost)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN: begin
                if (link_rst)            state_d = ST_RUN;
                else if (sync_ev)        state_d = ST_SYNC_LOCK;
                else if (crc_ev != '0)   state_d = ST_CRC_LOCK;
            end
            ST_CRC_LOCK: begin
                if (link_rst)            state_d = ST_RUN;
                else if (sync_ev)        state_d = ST_SYNC_LOCK;
                else if (soft_frame)     state_d = ST_RUN;
            end
            ST_SYNC_LOCK: begin
                if (link_rst)            state_d = ST_RUN;
            end
            default:                     state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        ev         = '0;
        log_go     = 1'b0;
        sr_go      = 1'b0;
        cmd_exec   = 1'b0;
        alert_stop = link_rst;
        unique case (state)
            ST_RUN: begin
                if (!link_rst) begin
                    ev         = crc_ev;
                    ev[E_SYNC] = sync_ev;
                    log_go     = (ev != '0);
                    sr_go      = sync_ev;
                    cmd_exec   = frame_valid && (ev == '0);
                end
            end
            ST_CRC_LOCK: begin
                if (!link_rst && sync_ev) begin
                    ev[E_SYNC] = 1'b1;
                    log_go     = 1'b1;
                    sr_go      = 1'b1;
                end
                if (soft_frame && !sync_ev) alert_stop = 1'b1;
            end
            ST_SYNC_LOCK: begin
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            self_refresh_req <= 1'b0;
        end else begin
            self_refresh_req <= sr_go;
        end
    end

    fault_log #(.FRAME_W(FRAME_W)) u_log (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (link_rst),
        .log_go      (log_go),
        .ev          (ev),
        .raw         (raw_frame),
        .log_strobe  (log_strobe),
        .log_frame   (log_frame),
        .first_err   (first_err),
        .next_err    (next_err),
        .alert_status(alert_status)
    );

    alert_slot_timer #(.DLY(ALERT_DLY)) u_alert (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (log_go),
        .stop     (alert_stop),
        .alert_sel(alert_sel)
    );

endmodule

// File: rtl/link_fault_ctrl_chk.sv
module link_fault_ctrl_chk
    import lfc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input lfc_state_e       state,
    input logic             frame_valid,
    input logic             link_rst,
    input logic             cmd_exec,
    input logic             log_strobe,
    input logic             alert_status,
    input logic [ERR_W-1:0] first_err,
    input logic             self_refresh_req,
    input logic             alert_sel
);

    assert_exec_needs_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_exec |-> frame_valid);

    assert_no_exec_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> !cmd_exec);

    assert_log_sets_alert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        log_strobe |-> alert_status);

    assert_first_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (first_err != '0 && !link_rst) |=> $stable(first_err));

    assert_sync_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC_LOCK && !link_rst) |=> (state == ST_SYNC_LOCK));

    assert_sr_only_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        self_refresh_req |-> (state == ST_SYNC_LOCK));

    assert_alert_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alert_sel |-> (state != ST_RUN));

    assert_link_rst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        link_rst |=> (first_err == '0 && !alert_sel && state == ST_RUN));

endmodule

bind link_fault_ctrl link_fault_ctrl_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .state           (state),
    .frame_valid     (frame_valid),
    .link_rst        (link_rst),
    .cmd_exec        (cmd_exec),
    .log_strobe      (log_strobe),
    .alert_status    (alert_status),
    .first_err       (first_err),
    .self_refresh_req(self_refresh_req),
    .alert_sel       (alert_sel)
);

// File: tb/tb_link_fault_ctrl.sv
module tb_link_fault_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int FW = 120;
    localparam int IW = 6;
    localparam int D  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          link_active = 1'b0;
    logic          frame_valid = 1'b0;
    logic          frame_is_sync = 1'b0;
    logic          crc_cmd_err = 1'b0;
    logic          crc_data_err = 1'b0;
    logic          soft_rst = 1'b0;
    logic          link_rst = 1'b0;
    logic [2:0]    err_mask = 3'b000;
    logic [IW-1:0] sync_interval = '0;
    logic [FW-1:0] raw_frame = '0;
    logic          cmd_exec;
    logic          log_strobe;
    logic [FW-1:0] log_frame;
    logic [2:0]    first_err;
    logic [2:0]    next_err;
    logic          alert_status;
    logic          self_refresh_req;
    logic          alert_sel;

    int nvec = 0;
    int nmis = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_fault_ctrl #(.FRAME_W(FW), .IVL_W(IW), .ALERT_DLY(D)) dut (
        .clk(clk), .rst_n(rst_n), .link_active(link_active),
        .frame_valid(frame_valid), .frame_is_sync(frame_is_sync),
        .crc_cmd_err(crc_cmd_err), .crc_data_err(crc_data_err),
        .soft_rst(soft_rst), .link_rst(link_rst), .err_mask(err_mask),
        .sync_interval(sync_interval), .raw_frame(raw_frame),
        .cmd_exec(cmd_exec), .log_strobe(log_strobe), .log_frame(log_frame),
        .first_err(first_err), .next_err(next_err), .alert_status(alert_status),
        .self_refresh_req(self_refresh_req), .alert_sel(alert_sel)
    );

    task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; ex returns cmd_exec sampled before the edge.
    task automatic step(input logic fv, input logic fs, input logic ce, input logic de,
                        input logic sr, input logic lr, input logic [FW-1:0] raw,
                        output logic ex);
        @(negedge clk);
        frame_valid = fv; frame_is_sync = fs; crc_cmd_err = ce;
        crc_data_err = de; soft_rst = sr; link_rst = lr; raw_frame = raw;
        #1 ex = cmd_exec;
        @(posedge clk);
        #1;
        frame_valid = 1'b0; frame_is_sync = 1'b0; crc_cmd_err = 1'b0;
        crc_data_err = 1'b0; soft_rst = 1'b0; link_rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [FW-1:0] pat(input int i);
        logic [14:0] s;
        s = 15'(i * 1237 + 91);
        return {8{s}};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nmis++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    initial begin
        logic ex;
        // R12: reset state
        repeat (2) @(posedge clk);
        #1;
        check("R12 cmd_exec", cmd_exec, 0);
        check("R12 log_strobe", log_strobe, 0);
        check("R12 first_err", first_err, 0);
        check("R12 next_err", next_err, 0);
        check("R12 alert_status", alert_status, 0);
        check("R12 self_refresh_req", self_refresh_req, 0);
        check("R12 alert_sel", alert_sel, 0);
        @(negedge clk);
        rst_n = 1'b1;
        link_active = 1'b1;
        sync_interval = IW'(30);

        // CRC sweep over every mask and fault kind
        for (int m = 0; m < 8; m++) begin
            for (int k = 1; k < 4; k++) begin
                logic [2:0] mv, ev, f, ev3;
                logic ce, de;
                mv = 3'(m);
                ce = k[0]; de = k[1];
                step(0, 0, 0, 0, 0, 1, '0, ex);
                err_mask = mv;
                ev = mv & {1'b0, de, ce};
                step(1, 0, ce, de, 0, 0, pat(m * 4 + k), ex);
                check("R2/R3 exec on fault frame", ex, ev == 0);
                check("R3 log_strobe", log_strobe, ev != 0);
                check("R4 first_err", first_err, ev);
                check("R8 no self refresh on CRC", self_refresh_req, 0);
                if (ev != 0) begin
                    check("R3 log_frame", log_frame, pat(m * 4 + k));
                    check("R3 alert_status", alert_status, 1);
                end
                step(1, 0, 0, 0, 0, 0, pat(100), ex);
                check("R5 exec after fault", ex, ev == 0);
                step(1, 0, 1, 0, 0, 0, pat(101), ex);
                if (ev != 0) begin
                    check("R11 locked exec", ex, 0);
                    check("R11 no log in lock", log_strobe, 0);
                    check("R11 next_err untouched", next_err, 0);
                    f = ev;
                end else begin
                    check("R2/R3 cmd crc exec", ex, !mv[0]);
                    check("R4 first_err cmd", first_err, {2'b00, mv[0]});
                    f = {2'b00, mv[0]};
                end
                step(1, 0, 0, 0, 1, 0, pat(102), ex);
                step(1, 0, 0, 0, 0, 0, pat(103), ex);
                check("R5 soft reset unlocks", ex, 1);
                ev3 = {1'b0, mv[1], 1'b0};
                step(1, 0, 0, 1, 0, 0, pat(104), ex);
                check("R4 first_err kept", first_err, (f != 0) ? f : ev3);
                check("R4 next_err", next_err, (f != 0) ? ev3 : 3'b000);
            end
        end

        // R9: alert slot timing
        err_mask = 3'b111;
        step(0, 0, 0, 0, 0, 1, '0, ex);
        step(1, 0, 1, 0, 0, 0, pat(7), ex);
        check("R9 alert_sel at strobe", alert_sel, 0);
        for (int j = 1; j < D; j++) begin
            idle(1);
            check("R9 alert_sel before slot", alert_sel, 0);
        end
        idle(1);
        check("R9 alert_sel at slot", alert_sel, 1);
        idle(3);
        check("R9 alert_sel holds", alert_sel, 1);
        step(1, 0, 0, 0, 1, 0, pat(8), ex);
        check("R9 alert_sel off after soft reset", alert_sel, 0);

        // R6/R7/R10: sync window sweep
        err_mask = 3'b100;
        for (int n = 1; n < 5; n++) begin
            sync_interval = IW'(n);
            step(0, 0, 0, 0, 0, 1, '0, ex);
            for (int j = 0; j < 2 * n - 1; j++) begin
                step(1, 0, 0, 0, 0, 0, pat(j), ex);
                check("R6 exec inside window", ex, 1);
            end
            step(1, 1, 0, 0, 0, 0, pat(50), ex);
            check("R6 sync frame exec", ex, 1);
            for (int j = 0; j < 2 * n - 1; j++) begin
                step(1, 0, 0, 0, 0, 0, pat(j + 60), ex);
                check("R6 exec after reload", ex, 1);
                check("R6 no self refresh yet", self_refresh_req, 0);
            end
            step(1, 0, 0, 0, 0, 0, pat(200 + n), ex);
            check("R7 expiring frame blocked", ex, 0);
            check("R7 self_refresh_req", self_refresh_req, 1);
            check("R7 log_strobe", log_strobe, 1);
            check("R7 log_frame", log_frame, pat(200 + n));
            check("R7 first_err", first_err, 3'b100);
            idle(1);
            check("R7 self refresh pulse ends", self_refresh_req, 0);
            step(1, 0, 0, 0, 1, 0, pat(9), ex);
            check("R7 soft reset blocked", ex, 0);
            step(1, 0, 0, 0, 0, 0, pat(10), ex);
            check("R7 still locked after soft reset", ex, 0);
            check("R7 alert_status kept", alert_status, 1);
            step(0, 0, 0, 0, 0, 1, '0, ex);
            check("R10 first_err cleared", first_err, 0);
            check("R10 next_err cleared", next_err, 0);
            check("R10 alert_status cleared", alert_status, 0);
            check("R10 alert_sel cleared", alert_sel, 0);
            step(1, 0, 0, 0, 0, 0, pat(11), ex);
            check("R10 exec after link reset", ex, 1);
        end

        // R6: counting held while link inactive
        sync_interval = IW'(1);
        step(0, 0, 0, 0, 0, 1, '0, ex);
        step(1, 0, 0, 0, 0, 0, pat(1), ex);
        link_active = 1'b0;
        for (int j = 0; j < 3; j++) begin
            step(1, 0, 0, 0, 0, 0, pat(2), ex);
            check("R6 inactive link no loss", ex, 1);
        end
        check("R6 inactive no self refresh", self_refresh_req, 0);
        link_active = 1'b1;
        step(1, 0, 0, 0, 0, 0, pat(3), ex);
        check("R6 loss after resume", ex, 0);
        check("R6 self refresh after resume", self_refresh_req, 1);

        // R2: masked sync loss
        err_mask = 3'b011;
        step(0, 0, 0, 0, 0, 1, '0, ex);
        for (int j = 0; j < 3; j++) begin
            step(1, 0, 0, 0, 0, 0, pat(4), ex);
            check("R2 masked sync loss exec", ex, 1);
            check("R2 masked sync loss no log", log_strobe, 0);
        end

        // R11: CRC lockout escalates to sync lockout
        err_mask = 3'b111;
        sync_interval = IW'(2);
        step(0, 0, 0, 0, 0, 1, '0, ex);
        step(1, 0, 1, 0, 0, 0, pat(5), ex);
        for (int j = 0; j < 2; j++) begin
            step(1, 0, 0, 0, 0, 0, pat(6), ex);
            check("R8 no self refresh in CRC lock", self_refresh_req, 0);
        end
        step(1, 0, 0, 0, 0, 0, pat(12), ex);
        check("R11 escalation exec", ex, 0);
        check("R11 escalation self refresh", self_refresh_req, 1);
        check("R11 first_err", first_err, 3'b001);
        check("R11 next_err", next_err, 3'b100);
        check("R11 log_frame", log_frame, pat(12));
        step(0, 0, 0, 0, 0, 1, '0, ex);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

endmodule